// File: doc/BRIEF.md
# Timestamp Target-Time Interrupt Comparator

This block watches a free-running precision clock, presented as a seconds word and a nanoseconds word, and raises an interrupt when that clock reaches a target time written by software. Software first writes the nanoseconds part of the target into a holding register. It then writes the seconds part, which loads both halves into the compare register in the same cycle. Finally it arms the trigger. Each arming produces at most one target event, because the arm bit drops in hardware as soon as the trigger fires.

The same status flag also reports a wrap of the seconds counter from all-ones to zero. Each cause has its own sticky bit. A read of the status register returns both bits and clears them. If a new event arrives in the cycle of the clearing read, that event wins and its bit stays set. The interrupt pin is a level: it is high while any status bit is set and the interrupt mask bit is on.

Top module: `ts_target_cmp`

## Requirements
- R1: After reset, the arm bit, the mask bit, both status bits and the committed target (seconds and nanoseconds) are all zero, and `irqOut` is low.
- R2: While armed, the target event fires in any cycle where {sysSec, sysNsec} is greater than or equal to the committed target. Firing sets status bit 0 at the next clock edge. While disarmed, no target event is recorded.
- R3: Register address 0 is control: bit 0 is the arm bit and bit 1 is the mask bit, and both are readable. In the cycle the target event fires, the arm bit clears, and this takes precedence over a control write in the same cycle.
- R4: A write to address 1 loads only a nanoseconds holding register. A write to address 2 commits the written seconds and the held nanoseconds together as the new target. Reads of addresses 1 and 2 return the committed nanoseconds and seconds. Writing the holding register never changes the comparison.
- R5: When sysSec is all-ones in one cycle and zero in the next cycle, status bit 1 is set, whether or not the block is armed.
- R6: A read of address 3 returns the target-reached status in bit 0 and the seconds-overflow status in bit 1, and clears both bits. An event in the same cycle as that read leaves its own bit set.
- R7: `irqOut` is high exactly when the mask bit is set and at least one status bit is set.
- R8: The comparison treats seconds as the most significant part. A larger seconds value fires the trigger even when its nanoseconds value is below the target nanoseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysSec | input | SEC_W | Running system time, seconds |
| sysNsec | input | NS_W | Running system time, nanoseconds (0 to 999,999,999) |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, valid in the cycle of `regRdEn` |
| irqOut | output | 1 | Interrupt level |

## Verification
The comparison is tried against times one step below, equal to and one step above the target, in both the seconds word and the nanoseconds word. This separates a strict comparison from a greater-or-equal comparison, and shows whether seconds really outrank nanoseconds. Seconds values around the all-ones-to-zero wrap show whether overflow detection needs the actual transition or fires on a zero seconds value alone. Clearing reads that land on the same cycle as an event check that the event wins. Holding-register writes made while armed, with the sampled time already past that value, expose a compare that reads the holding register instead of the committed target.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TGT_NS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TGT_SEC = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd3;
  localparam int NUM_CAUSE = 2;

  typedef struct packed {
    logic stageNs;
    logic commitTgt;
    logic clrStatus;
  } tscStrobes_t;
endpackage

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  tscStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEC_W-1:0]  sysSec,
  input  logic [NS_W-1:0]   sysNsec,
  output logic [SEC_W-1:0]  tgtSec,
  output logic [NS_W-1:0]   tgtNs,
  output logic              hitNow,
  output logic              ovfPulse
);
  localparam int TIME_W = SEC_W + NS_W;

  logic [NS_W-1:0]   stageNs;
  logic [SEC_W-1:0]  prevSec;
  logic              prevValid;
  logic [TIME_W-1:0] nowTime;
  logic [TIME_W-1:0] tgtTime;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageNs   <= '0;
      tgtSec    <= '0;
      tgtNs     <= '0;
      prevSec   <= '0;
      prevValid <= 1'b0;
    end else begin
      if (strb.stageNs) stageNs <= NS_W'(wrData);
      if (strb.commitTgt) begin
        tgtSec <= SEC_W'(wrData);
        tgtNs  <= stageNs;
      end
      prevSec   <= sysSec;
      prevValid <= 1'b1;
    end
  end

  assign nowTime  = {sysSec, sysNsec};
  assign tgtTime  = {tgtSec, tgtNs};
  assign hitNow   = nowTime >= tgtTime;
  assign ovfPulse = prevValid && (&prevSec) && (sysSec == '0);

  // R5: an overflow pulse only on a real wrap between consecutive cycles
  assert_wrap_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (sysSec == '0) && ($past(sysSec) == {SEC_W{1'b1}}));

  // R4: a commit loads the written seconds and the previously held nanoseconds
  assert_commit_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitTgt |=> (tgtSec == $past(wrData[SEC_W-1:0])) && (tgtNs == $past(stageNs)));

  // R4: a holding-register write alone leaves the committed target unchanged
  assert_stage_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stageNs && !strb.commitTgt) |=> $stable(tgtNs) && $stable(tgtSec));
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        ctrlWrBits,
  input  logic              hitNow,
  input  logic              ovfPulse,
  input  logic [SEC_W-1:0]  tgtSec,
  input  logic [NS_W-1:0]   tgtNs,
  output tscStrobes_t       strb,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic                 armed;
  logic                 maskBit;
  logic [NUM_CAUSE-1:0] status;
  logic [NUM_CAUSE-1:0] causeSet;
  logic                 fireNow;
  logic                 wrCtrl;

  assign fireNow        = armed && hitNow;
  assign wrCtrl         = regWrEn && (regAddr == ADDR_CTRL);
  assign strb.stageNs   = regWrEn && (regAddr == ADDR_TGT_NS);
  assign strb.commitTgt = regWrEn && (regAddr == ADDR_TGT_SEC);
  assign strb.clrStatus = regRdEn && (regAddr == ADDR_STATUS);
  assign causeSet       = {ovfPulse, fireNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      maskBit <= 1'b0;
    end else begin
      if (wrCtrl) maskBit <= ctrlWrBits[1];
      if (fireNow)     armed <= 1'b0;
      else if (wrCtrl) armed <= ctrlWrBits[0];
    end
  end

  for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rstN) status[c] <= 1'b0;
      else       status[c] <= (status[c] && !strb.clrStatus) || causeSet[c];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        ADDR_CTRL:    regRdData = DATA_W'({maskBit, armed});
        ADDR_TGT_NS:  regRdData = DATA_W'(tgtNs);
        ADDR_TGT_SEC: regRdData = DATA_W'(tgtSec);
        default:      regRdData = DATA_W'(status);
      endcase
    end
  end

  assign irqOut = maskBit && (|status);

  // R3: firing drops the arm bit at the next edge
  assert_arm_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    fireNow |=> !armed);

  // R2: the reached bit only rises after an armed match
  assert_reached_needs_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(armed && hitNow));

  // R5: a wrap always lands in the overflow bit
  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> status[1]);

  // R6: a clearing read with no event in that cycle empties the status
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && !(|causeSet)) |=> (status == '0));

  // R7: a masked interrupt stays low
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    !maskBit |-> !irqOut);
endmodule

// File: rtl/ts_target_cmp.sv
module ts_target_cmp
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEC_W-1:0]  sysSec,
  input  logic [NS_W-1:0]   sysNsec,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  tscStrobes_t      strb;
  logic [SEC_W-1:0] tgtSec;
  logic [NS_W-1:0]  tgtNs;
  logic             hitNow;
  logic             ovfPulse;

  tsc_datapath #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .sysSec   (sysSec),
    .sysNsec  (sysNsec),
    .tgtSec   (tgtSec),
    .tgtNs    (tgtNs),
    .hitNow   (hitNow),
    .ovfPulse (ovfPulse)
  );

  tsc_ctrl #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .ctrlWrBits (regWrData[1:0]),
    .hitNow     (hitNow),
    .ovfPulse   (ovfPulse),
    .tgtSec     (tgtSec),
    .tgtNs      (tgtNs),
    .strb       (strb),
    .regRdData  (regRdData),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/test_ts_target_cmp.sv
`timescale 1ns/1ps
module test_ts_target_cmp;
  localparam int DATA_W = 32;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam logic [NS_W-1:0] NS_MAX = NS_W'(999_999_999);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [SEC_W-1:0]  sysSec = '0;
  logic [NS_W-1:0]   sysNsec = '0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [1:0]        regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic             mArm, mMask, mStR, mStO, mPv;
  logic [NS_W-1:0]  mStage, mTgtNs;
  logic [SEC_W-1:0] mTgtSec, mPrev;

  always #2 clk = ~clk;

  ts_target_cmp #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W)) i_ts_target_cmp (
    .clk(clk), .rstN(rstN), .sysSec(sysSec), .sysNsec(sysNsec),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic timeGe(logic [SEC_W-1:0] s, logic [NS_W-1:0] n,
                                  logic [SEC_W-1:0] ts, logic [NS_W-1:0] tn);
    if (s != ts) return s > ts;
    return n >= tn;
  endfunction

  function automatic logic [DATA_W-1:0] expRead(logic [1:0] a);
    case (a)
      2'd0:    return DATA_W'({mMask, mArm});
      2'd1:    return DATA_W'(mTgtNs);
      2'd2:    return DATA_W'(mTgtSec);
      default: return DATA_W'({mStO, mStR});
    endcase
  endfunction

  task automatic check(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mArm = 0; mMask = 0; mStR = 0; mStO = 0; mPv = 0;
    mStage = '0; mTgtNs = '0; mTgtSec = '0; mPrev = '0;
  endtask

  // one clock cycle: drive, check combinational and registered outputs, advance model
  task automatic cyc(string tag, logic [SEC_W-1:0] s, logic [NS_W-1:0] n,
                     logic we, logic re, logic [1:0] a, logic [DATA_W-1:0] d);
    logic hit, ovf, fire, wCtrl;
    @(negedge clk);
    sysSec = s; sysNsec = n; regWrEn = we; regRdEn = re; regAddr = a; regWrData = d;
    #1;
    check(tag, "irq", DATA_W'(irqOut), DATA_W'(mMask && (mStR || mStO)));
    if (re) check(tag, "read", regRdData, expRead(a));
    hit   = timeGe(s, n, mTgtSec, mTgtNs);
    ovf   = mPv && (mPrev == '1) && (s == '0);
    fire  = mArm && hit;
    wCtrl = we && (a == 2'd0);
    if (re && a == 2'd3) begin mStR = 0; mStO = 0; end
    if (fire) mStR = 1;
    if (ovf)  mStO = 1;
    if (wCtrl) mMask = d[1];
    if (fire) mArm = 0; else if (wCtrl) mArm = d[0];
    if (we && a == 2'd2) begin mTgtSec = SEC_W'(d); mTgtNs = mStage; end
    if (we && a == 2'd1) mStage = NS_W'(d);
    mPrev = s; mPv = 1;
  endtask

  task automatic idle(string tag, logic [SEC_W-1:0] s, logic [NS_W-1:0] n);
    cyc(tag, s, n, 0, 0, 2'd0, '0);
  endtask
  task automatic wr(string tag, logic [SEC_W-1:0] s, logic [NS_W-1:0] n, logic [1:0] a, logic [DATA_W-1:0] d);
    cyc(tag, s, n, 1, 0, a, d);
  endtask
  task automatic rd(string tag, logic [SEC_W-1:0] s, logic [NS_W-1:0] n, logic [1:0] a);
    cyc(tag, s, n, 0, 1, a, '0);
  endtask

  initial begin
    #400_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1588));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state visible through every register
    rd("R1", 5, 0, 2'd0);
    rd("R1", 5, 0, 2'd1);
    rd("R1", 5, 0, 2'd2);
    rd("R1", 5, 0, 2'd3);

    // R2: equal time fires, one below does not
    wr("R4", 9, 0, 2'd1, 32'd500);
    wr("R4", 9, 0, 2'd2, 32'd10);
    rd("R4", 9, 0, 2'd1);
    rd("R4", 9, 0, 2'd2);
    wr("R3", 9, 0, 2'd0, 32'd3);
    idle("R2", 10, 499);
    rd("R2", 10, 499, 2'd3);
    idle("R2", 10, 500);
    idle("R7", 10, 501);
    rd("R3", 10, 502, 2'd0);
    idle("R3", 10, 503);
    rd("R6", 10, 504, 2'd3);
    rd("R6", 10, 505, 2'd3);
    idle("R7", 10, 506);

    // R8: seconds outrank nanoseconds
    wr("R8", 10, 0, 2'd1, 32'd900);
    wr("R8", 10, 0, 2'd2, 32'd20);
    wr("R8", 10, 0, 2'd0, 32'd3);
    idle("R8", 19, NS_MAX);
    idle("R8", 21, 0);
    rd("R8", 21, 1, 2'd3);

    // R5: wrap sets overflow while disarmed; zero alone does not
    wr("R5", 0, 0, 2'd0, 32'd2);
    idle("R5", 0, 0);
    rd("R5", 1, 0, 2'd3);
    idle("R5", '1, 0);
    idle("R5", 0, 0);
    rd("R5", 0, 1, 2'd3);
    // R6: wrap in the cycle of the clearing read keeps bit 1
    idle("R6", '1, 0);
    rd("R6", 0, 0, 2'd3);
    rd("R6", 0, 1, 2'd3);
    rd("R6", 0, 2, 2'd3);

    // R4: holding-register write while armed does not fire
    wr("R4", 50, 0, 2'd1, 32'd7);
    wr("R4", 50, 0, 2'd2, 32'd100);
    wr("R4", 50, 0, 2'd0, 32'd3);
    wr("R4", 60, 10, 2'd1, 32'd0);
    idle("R4", 60, 10);
    rd("R4", 60, 10, 2'd3);
    wr("R4", 60, 10, 2'd2, 32'd60);
    idle("R4", 60, 10);
    rd("R4", 60, 10, 2'd3);

    // random mix around the target
    for (int i = 0; i < 4000; i++) begin
      logic [SEC_W-1:0] s;
      logic [NS_W-1:0] n;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: s = '1;
        1: s = '0;
        default: s = mTgtSec + SEC_W'($urandom_range(0, 2)) - SEC_W'(1);
      endcase
      pick = $urandom_range(0, 4);
      case (pick)
        0: n = (mTgtNs == 0) ? '0 : mTgtNs - 1;
        1: n = mTgtNs;
        2: n = (mTgtNs >= NS_MAX) ? NS_MAX : mTgtNs + 1;
        3: n = '0;
        default: n = NS_W'($urandom_range(0, 999_999_999));
      endcase
      pick = $urandom_range(0, 19);
      case (pick)
        0, 1: wr("R3", s, n, 2'd0, DATA_W'($urandom_range(0, 3)));
        2: wr("R4", s, n, 2'd1, DATA_W'($urandom_range(0, 999_999_999)));
        3: wr("R4", s, n, 2'd2, DATA_W'($urandom_range(0, 40)));
        4, 5, 6: rd("R6", s, n, 2'($urandom_range(0, 3)));
        default: idle("R2", s, n);
      endcase
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule